// File: doc/BRIEF.md
# Memory Data-Bus Line Test Engine

This block is a built-in self-test sequencer that checks the data lines of a 64-bit memory bus for shorts and opens. It drives a plain word-addressed memory port, with request, write enable, address, write data, returned read data and a read-valid strobe. It steps through a fixed table of walking-block patterns and their complements.

For every pattern the engine performs three operations. It first writes the pattern to a target word. It then writes a fixed decoy word to the next address, so that the bus is recharged to a different value. Last, it reads the target word back once. The engine never stops early. When the sequence ends it gives a done pulse, a sticky fail flag, and a record of the first mismatch: the pattern index, the expected word and the word actually read.

A controller starts a run with a single-cycle start pulse. The target base address is presented on an input and sampled on that pulse.

Top module: `dbus_bist`

## Requirements
- R1: After reset, busy_o, done_o, fail_o and mem_req_o are 0, and the three capture outputs are 0.
- R2: The patterns are applied in index order 0 to 11. Indices 0 to 5 are AAAAAAAAAAAAAAAA, CCCCCCCCCCCCCCCC, F0F0F0F0F0F0F0F0, FF00FF00FF00FF00, FFFF0000FFFF0000 and FFFFFFFF00000000. Indices 6 to 11 are 00000000FFFFFFFF, 0000FFFF0000FFFF, 00FF00FF00FF00FF, 0F0F0F0F0F0F0F0F, 3333333333333333 and 5555555555555555.
- R3: Each pattern is handled by three operations on consecutive request cycles. First comes a write (mem_we_o=1) of the pattern to the base address. Next comes a write of 0123456789ABCDEF to base+1, wrapping modulo the address width. Last comes a read (mem_we_o=0) of the base address.
- R4: Each pattern gets exactly one read. After a read request, no further request is issued until mem_rvalid_i has been seen, and the data returned with that strobe is the value that is compared and reported.
- R5: A read word that differs from its pattern sets fail_o. fail_o stays set until the next accepted start, and all 12 patterns (36 operations) are still executed.
- R6: On the first mismatch of a run, fail_idx_o, fail_exp_o and fail_got_o take the pattern index, the pattern and the read word. Later mismatches do not change them. An accepted start clears them and fail_o to 0.
- R7: busy_o is 1 from the cycle after an accepted start until done_o. done_o is a single-cycle pulse in the cycle after the final read response, and fail_o and the capture outputs are final in that cycle.
- R8: base_i is sampled only when a start is accepted. Changes to base_i during a run have no effect on the addresses issued.
- R9: A start_i pulse while busy_o is 1 is ignored. The run in progress keeps its base address and its operation count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| base_i | input | ADDR_W | Target word address, sampled at start |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_idx_o | output | IDX_W | Pattern index of first mismatch |
| fail_exp_o | output | DATA_W | Expected word of first mismatch |
| fail_got_o | output | DATA_W | Read word of first mismatch |
| mem_req_o | output | 1 | Memory request strobe |
| mem_we_o | output | 1 | Write enable (1 write, 0 read) |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid with mem_rvalid_i |
| mem_rvalid_i | input | 1 | Read response strobe |

## Verification
The bench targets the bus-echo case. Here the memory keeps nothing and returns the last word driven, so an engine without the decoy write would report a pass; the correct engine must report a fail at index 0 with the decoy word as the value read. Stuck-at-0 data lines are injected at random bit positions. The bench checks that the captured index is the first pattern that touches the line, and that a design which stopped early or overwrote the capture would be caught by the operation count and by the held fields. Read latency is randomised, so an engine that compared before the read-valid strobe, or issued a second read, would miscompare. Stray start pulses and base changes during a run would show up as wrong addresses. Finally, a base at the top of the address range checks that the decoy address wraps.

// File: rtl/dbus_bist_pkg.sv
package dbus_bist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_PAT,
    ST_WR_DECOY,
    ST_RD_REQ,
    ST_RD_WAIT
  } bist_st_e;

  localparam logic [63:0] DECOY_WORD = 64'h0123_4567_89AB_CDEF;
endpackage

// File: rtl/dbus_bist_patgen.sv
module dbus_bist_patgen #(
  parameter int DATA_W   = 64,
  parameter int NUM_BASE = $clog2(DATA_W),
  parameter int NUM_PAT  = 2 * NUM_BASE,
  parameter int IDX_W    = $clog2(NUM_PAT)
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] pat_o
);
  logic [DATA_W-1:0] base_tbl [NUM_BASE];

  // base g: bit b set when bit g of b is 1 -> blocks of 2^g alternate
  for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign base_tbl[g][b] = ((b / (1 << g)) % 2) == 1;
    end
  end

  always_comb begin
    int i;
    i = int'(idx_i);
    pat_o = '0;
    if (i < NUM_BASE)
      pat_o = base_tbl[i];
    else if (i < NUM_PAT)
      pat_o = ~base_tbl[NUM_PAT-1-i];
  end
endmodule

// File: rtl/dbus_bist_ctrl.sv
module dbus_bist_ctrl
  import dbus_bist_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 64,
  parameter int          NUM_PAT = 12,
  parameter int          IDX_W   = $clog2(NUM_PAT),
  parameter logic [63:0] DECOY   = DECOY_WORD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] pat_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              clr_o,
  output logic              cmp_vld_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i
);
  localparam logic [DATA_W-1:0] DECOY_W = DECOY[DATA_W-1:0];
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_PAT - 1);

  bist_st_e          st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] base_q;
  logic              done_q;
  logic              accept;
  logic              last_rsp;

  assign accept    = start_i && (st_q == ST_IDLE);
  assign cmp_vld_o = (st_q == ST_RD_WAIT) && mem_rvalid_i;
  assign last_rsp  = cmp_vld_o && (idx_q == LAST_IDX);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_IDLE:     if (accept) begin
                     st_d  = ST_WR_PAT;
                     idx_d = '0;
                   end
      ST_WR_PAT:   st_d = ST_WR_DECOY;
      ST_WR_DECOY: st_d = ST_RD_REQ;
      ST_RD_REQ:   st_d = ST_RD_WAIT;
      ST_RD_WAIT:  if (cmp_vld_o) begin
                     if (last_rsp) st_d = ST_IDLE;
                     else begin
                       st_d  = ST_WR_PAT;
                       idx_d = idx_q + 1'b1;
                     end
                   end
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      base_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= last_rsp;
      if (accept) base_q <= base_i;
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = base_q;
    mem_wdata_o = '0;
    unique case (st_q)
      ST_WR_PAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = pat_i;
      end
      ST_WR_DECOY: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = base_q + ADDR_W'(1);
        mem_wdata_o = DECOY_W;
      end
      ST_RD_REQ: mem_req_o = 1'b1;
      default: ;
    endcase
  end

  assign idx_o  = idx_q;
  assign clr_o  = accept;
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;

  // R3
  decoy_after_pat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WR_PAT) |=> (mem_req_o && mem_we_o && mem_wdata_o == DECOY_W &&
                             mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));
  // R4
  one_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> !mem_req_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !cmp_vld_o) |=> busy_o && $stable(base_q));
endmodule

// File: rtl/dbus_bist_cap.sv
module dbus_bist_cap #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cmp_vld_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] got_i,
  output logic              fail_o,
  output logic [IDX_W-1:0]  fail_idx_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_got_o
);
  logic              fail_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] exp_q, got_q;
  logic              miss;

  assign miss = cmp_vld_i && (got_i != exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      idx_q  <= '0;
      exp_q  <= '0;
      got_q  <= '0;
    end else if (clr_i) begin
      fail_q <= 1'b0;
      idx_q  <= '0;
      exp_q  <= '0;
      got_q  <= '0;
    end else if (miss && !fail_q) begin
      fail_q <= 1'b1;
      idx_q  <= idx_i;
      exp_q  <= exp_i;
      got_q  <= got_i;
    end
  end

  assign fail_o     = fail_q;
  assign fail_idx_o = idx_q;
  assign fail_exp_o = exp_q;
  assign fail_got_o = got_q;

  // R5
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !clr_i) |=> fail_q);
  // R6
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !clr_i) |=> ($stable(got_q) && $stable(exp_q) && $stable(idx_q)));
endmodule

// File: rtl/dbus_bist.sv
module dbus_bist
  import dbus_bist_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 64,
  parameter logic [63:0] DECOY    = DECOY_WORD,
  parameter int          NUM_BASE = $clog2(DATA_W),
  parameter int          NUM_PAT  = 2 * NUM_BASE,
  parameter int          IDX_W    = $clog2(NUM_PAT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [IDX_W-1:0]  fail_idx_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_got_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rvalid_i
);
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] pat;
  logic              clr, cmp_vld;

  dbus_bist_patgen #(
    .DATA_W(DATA_W), .NUM_BASE(NUM_BASE), .NUM_PAT(NUM_PAT), .IDX_W(IDX_W)
  ) u_patgen (
    .idx_i(idx),
    .pat_o(pat)
  );

  dbus_bist_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PAT(NUM_PAT), .IDX_W(IDX_W), .DECOY(DECOY)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .base_i      (base_i),
    .pat_i       (pat),
    .idx_o       (idx),
    .clr_o       (clr),
    .cmp_vld_o   (cmp_vld),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rvalid_i(mem_rvalid_i)
  );

  dbus_bist_cap #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .cmp_vld_i (cmp_vld),
    .idx_i     (idx),
    .exp_i     (pat),
    .got_i     (mem_rdata_i),
    .fail_o    (fail_o),
    .fail_idx_o(fail_idx_o),
    .fail_exp_o(fail_exp_o),
    .fail_got_o(fail_got_o)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
endmodule

// File: tb/dbus_bist_bench.sv
module dbus_bist_bench;
  localparam int AW = 16;
  localparam int DW = 64;
  localparam logic [63:0] DEC = 64'h0123456789ABCDEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] base = '0;
  logic busy, done, fail;
  logic [3:0] f_idx;
  logic [DW-1:0] f_exp, f_got;
  logic req, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata = '0;
  logic rvalid = 1'b0;

  always #5 clk = ~clk;

  dbus_bist u_dbus_bist (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base),
    .busy_o(busy), .done_o(done), .fail_o(fail), .fail_idx_o(f_idx),
    .fail_exp_o(f_exp), .fail_got_o(f_got), .mem_req_o(req), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_rvalid_i(rvalid)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  function automatic logic [63:0] pat(int k);
    case (k)
      0: return 64'hAAAAAAAAAAAAAAAA;  1: return 64'hCCCCCCCCCCCCCCCC;
      2: return 64'hF0F0F0F0F0F0F0F0;  3: return 64'hFF00FF00FF00FF00;
      4: return 64'hFFFF0000FFFF0000;  5: return 64'hFFFFFFFF00000000;
      6: return 64'h00000000FFFFFFFF;  7: return 64'h0000FFFF0000FFFF;
      8: return 64'h00FF00FF00FF00FF;  9: return 64'h0F0F0F0F0F0F0F0F;
      10: return 64'h3333333333333333; 11: return 64'h5555555555555555;
      default: return 64'h0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // SRAM model with fault options
  logic [DW-1:0] mem [256];
  logic [DW-1:0] stuck0 = '0;
  bit echo = 0;
  int lat_max = 0;
  bit rd_pend = 0;
  int rd_cnt = 0;
  logic [7:0] rd_addr;
  logic [DW-1:0] last_w = '0;

  always @(posedge clk) begin
    rvalid <= 1'b0;
    if (rd_pend) begin
      if (rd_cnt == 0) begin
        rvalid  <= 1'b1;
        rdata   <= echo ? last_w : (mem[rd_addr] & ~stuck0);
        rd_pend <= 0;
      end else rd_cnt <= rd_cnt - 1;
    end
    if (req && !we) begin
      rd_pend <= 1;
      rd_cnt  <= $urandom_range(lat_max, 0);
      rd_addr <= addr[7:0];
    end
    if (req && we) begin
      mem[addr[7:0]] <= wdata;
      last_w <= wdata;
    end
  end

  // operation monitor
  int op_n = 0;
  logic [AW-1:0] exp_base = '0;
  bit outstanding = 0;

  always @(negedge clk) begin
    if (rvalid) outstanding = 0;
    if (req && rst_n) begin
      int k, o;
      k = op_n / 3;
      o = op_n % 3;
      chk(op_n < 36, "R5 op count overflow", 64'(op_n), 64'd35);
      chk(!outstanding, "R4 request while read pending", 64'(op_n), 64'd0);
      case (o)
        0: begin
          chk(we && addr == exp_base, "R3 pattern write addr", 64'(addr), 64'(exp_base));
          chk(wdata == pat(k), "R2 pattern order", wdata, pat(k));
        end
        1: begin
          chk(we && addr == exp_base + AW'(1), "R3 decoy addr", 64'(addr), 64'(exp_base + AW'(1)));
          chk(wdata == DEC, "R3 decoy value", wdata, DEC);
        end
        default: begin
          chk(!we && addr == exp_base, "R8 read addr", 64'(addr), 64'(exp_base));
          outstanding = 1;
        end
      endcase
      op_n++;
    end
  end

  task automatic run(logic [AW-1:0] b, logic [DW-1:0] s0, bit ec, int lm, bit disturb);
    bit e_fail;
    int e_idx;
    logic [63:0] e_exp, e_got;
    int guard;
    stuck0 = s0; echo = ec; lat_max = lm;
    e_fail = 0; e_idx = 0; e_exp = 0; e_got = 0;
    for (int k = 0; k < 12; k++) begin
      logic [63:0] g;
      g = ec ? DEC : (pat(k) & ~s0);
      if (!e_fail && g != pat(k)) begin
        e_fail = 1; e_idx = k; e_exp = pat(k); e_got = g;
      end
    end
    @(negedge clk);
    exp_base = b; op_n = 0;
    base = b; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy, "R7 busy after start", 64'(busy), 64'd1);
    chk(!fail && f_got == 0 && f_exp == 0, "R6 cleared on start", f_got, 64'd0);
    guard = 0;
    while (!done && guard < 2000) begin
      if (guard == 3) base = ~b;
      if (disturb && guard == 10) begin start = 1; base = b ^ 16'h00F0; end
      if (disturb && guard == 11) start = 0;
      @(negedge clk);
      guard++;
    end
    chk(done, "R7 done seen", 64'(done), 64'd1);
    chk(!busy, "R7 busy low at done", 64'(busy), 64'd0);
    chk(op_n == 36, "R5 all patterns run", 64'(op_n), 64'd36);
    chk(fail == e_fail, "R5 fail flag", 64'(fail), 64'(e_fail));
    chk(int'(f_idx) == e_idx, "R6 fail index", 64'(f_idx), 64'(e_idx));
    chk(f_exp == e_exp, "R6 fail expected", f_exp, e_exp);
    chk(f_got == e_got, "R6 fail read word", f_got, e_got);
    @(negedge clk);
    chk(!done, "R7 done single pulse", 64'(done), 64'd0);
    chk(fail == e_fail && int'(f_idx) == e_idx && f_got == e_got, "R6 hold after done", f_got, e_got);
    repeat (2) @(negedge clk);
    chk(op_n == 36 && !busy, "R9 no extra run", 64'(op_n), 64'd36);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !req, "R1 reset outputs", {busy, done, fail, req}, 64'd0);
    chk(f_got == 0 && f_exp == 0 && f_idx == 0, "R1 reset capture", f_got, 64'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !req, "R1 idle after reset", {busy, req}, 64'd0);

    run(16'd20, '0, 0, 0, 0);
    run(16'hFFFF, '0, 0, 2, 0);               // decoy address wraps
    run(16'd100, '0, 1, 1, 0);                // floating bus echo
    run(16'd40, '0, 0, 3, 0);                 // clears previous capture (R6)
    run(16'd60, 64'h1, 0, 0, 1);              // stuck bit 0, stray start (R9)
    run(16'd70, 64'h8000_0000_0000_0000, 0, 2, 0);
    for (int i = 0; i < 14; i++) begin
      logic [DW-1:0] m;
      m = (i % 3 == 0) ? '0 : (64'h1 << $urandom_range(63, 0));
      if (i % 4 == 1) m = m | (64'h1 << $urandom_range(63, 0));
      run(AW'($urandom_range(250, 0)), m, 0, $urandom_range(3, 0), i[0]);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R7 watchdog expired act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule